// File: doc/BRIEF.md
# Bus-Cycle Wait-State and Ready Sequencer

This block paces one external bus access at a time. A plain access runs through four clock phases: address phase T1, command phase T2, data phase T3 and completion phase T4. The sequencer can add wait cycles between T3 and T4. The number of wait cycles comes from a small code supplied with the access. If the access's region asks for it, the sequencer also stretches the cycle until an external ready signal is seen. Address decoding lives elsewhere. The surrounding logic presents the decoded wait code, the ready-required flag and an internal-register flag together with the start request.

Two ready sources are accepted. The first is a ready that may change at any time relative to the clock, and it goes through a flip-flop synchronizer. The second is a ready that already meets setup to the clock edge, and it is used directly. The programmed waits always run before ready can end the cycle. Ready is checked one wait before the last programmed wait. Once ready has been seen, exactly one more programmed wait follows, then T4. Accesses to the on-chip register block always take four clocks.

Top module: `bus_wait_ctl`

## Requirements
- R1: After reset and with no access, all phase outputs are low. An accepted start makes `ph_t1` high in the next clock, then `ph_t2`, then `ph_t3`. At most one of `ph_t1`, `ph_t2`, `ph_t3`, `ph_tw`, `cyc_done` is high in any clock.
- R2: The programmed wait count N is decoded from `wait_code`. With `wide_sel`=0, N is `wait_code[1:0]` (0 to 3). With `wide_sel`=1, codes 0 to 3 give 0 to 3 and codes 4, 5, 6, 7 give 5, 7, 9, 15.
- R3: With `rdy_req`=0, every access lasts exactly 4+N clocks from `ph_t1` through `cyc_done` inclusive, whatever `ardy` and `srdy` do.
- R4: With `rdy_req`=1, ready is sampled in clock 3 (T3) when N is 0 or 1, and in clock 2+N (wait cycle N-1) otherwise. If ready is high there, the access lasts 4+N clocks.
- R5: With `rdy_req`=1, each sample that finds ready low adds one wait cycle, and the sample is repeated. After ready is seen, the remaining programmed waits (one wait, or none when N=0) follow, then `cyc_done`. The total is 4+N+E clocks, where E counts the failed samples.
- R6: Effective ready is `srdy` OR the synchronized `ardy`. An `ardy` change driven during clock c is seen by a sample in clock c+2 or later.
- R7: With `int_acc`=1, the access lasts 4 clocks, ignoring `wait_code`, `wide_sel`, `rdy_req` and both ready inputs.
- R8: `cyc_done` is high for one clock, the last clock of each access. Intermediate clocks after T3 show `ph_tw`.
- R9: `start` is accepted only when idle or in the `cyc_done` clock. A start during `cyc_done` gives `ph_t1` in the very next clock. A start held during T1 to T3 has no effect on those phases.
- R10: The configuration inputs are captured when the start is accepted. Changing them later in the access does not change its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an access |
| wait_code | input | 3 | Wait-state code for the access |
| wide_sel | input | 1 | Selects the extended wait table |
| rdy_req | input | 1 | Region requires external ready |
| int_acc | input | 1 | Access targets the on-chip register block |
| ardy | input | 1 | Ready, asynchronous to clk, active high |
| srdy | input | 1 | Ready, synchronous to clk, active high |
| ph_t1 | output | 1 | Address phase |
| ph_t2 | output | 1 | Command phase |
| ph_t3 | output | 1 | Data phase |
| ph_tw | output | 1 | Wait cycle |
| cyc_done | output | 1 | Final clock of the access |

## Verification
The main sweep covers every wait code in both table modes, with ready required and not, with internal accesses on and off. Synchronous ready first rises after a range of delays. Some delays fall before the sample point and some after it, which separates a sample placed too early or too late from correct behaviour. Configuration inputs are inverted one clock after acceptance to show they are captured at the start. Separate runs use the asynchronous ready, both held high in advance and raised mid-access, to measure the synchronizer's delay. A run that holds start high shows back-to-back acceptance and shows that start is ignored in the middle phases.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  localparam int WAIT_W = 5;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  // Programmed waits for a code; extended table for the upper codes.
  function automatic logic [WAIT_W-1:0] waits_of(input logic [2:0] code,
                                                  input logic       wide);
    logic [WAIT_W-1:0] n;
    if (!wide || !code[2]) begin
      n = WAIT_W'(code[1:0]);
    end else begin
      case (code[1:0])
        2'd0:    n = WAIT_W'(5);
        2'd1:    n = WAIT_W'(7);
        2'd2:    n = WAIT_W'(9);
        default: n = WAIT_W'(15);
      endcase
    end
    return n;
  endfunction

  // Remaining-wait level at which ready is sampled inside the wait phase.
  function automatic logic [WAIT_W-1:0] sample_level(input logic [WAIT_W-1:0] n);
    return (n == '0) ? WAIT_W'(1) : WAIT_W'(2);
  endfunction

endpackage

// File: rtl/bwc_rdy_sync.sv
module bwc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bwc_cfg.sv
module bwc_cfg
  import bwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2:0]        code,
  input  logic              wide,
  input  logic              req,
  input  logic              intr,
  output logic [WAIT_W-1:0] n_lat,
  output logic              need_lat
);
  logic [WAIT_W-1:0] n_in;
  logic              need_in;

  always_comb begin
    n_in    = intr ? '0 : waits_of(code, wide);
    need_in = req && !intr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_lat    <= '0;
      need_lat <= 1'b0;
    end else if (load) begin
      n_lat    <= n_in;
      need_lat <= need_in;
    end
  end
endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
  import bwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] n_waits,
  input  logic              need,
  input  logic              rdy_eff,
  output phase_e            phase,
  output logic              accept,
  output logic              samp_pt,
  output logic [WAIT_W-1:0] left
);
  phase_e            ph_nx;
  logic [WAIT_W-1:0] left_nx;
  logic [WAIT_W-1:0] slvl;
  logic              small_n;
  logic              rdy_ok;

  always_comb begin
    slvl    = sample_level(n_waits);
    small_n = (n_waits <= WAIT_W'(1));
    accept  = start && (phase == PH_IDLE || phase == PH_T4);
    samp_pt = need && ((phase == PH_T3 && small_n) ||
                       (phase == PH_TW && left == slvl));
    rdy_ok  = !samp_pt || rdy_eff;
  end

  always_comb begin
    ph_nx   = phase;
    left_nx = left;
    case (phase)
      PH_IDLE: if (accept) ph_nx = PH_T1;
      PH_T1:   ph_nx = PH_T2;
      PH_T2:   ph_nx = PH_T3;
      PH_T3: begin
        if (!small_n) begin
          ph_nx   = PH_TW;
          left_nx = n_waits;
        end else if (rdy_ok) begin
          if (n_waits == '0) begin
            ph_nx = PH_T4;
          end else begin
            ph_nx   = PH_TW;
            left_nx = WAIT_W'(1);
          end
        end else begin
          ph_nx   = PH_TW;
          left_nx = n_waits + WAIT_W'(1);
        end
      end
      PH_TW: begin
        if (rdy_ok) begin
          if (left == WAIT_W'(1)) ph_nx = PH_T4;
          else                    left_nx = left - WAIT_W'(1);
        end
      end
      PH_T4:   ph_nx = accept ? PH_T1 : PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      left  <= '0;
    end else begin
      phase <= ph_nx;
      left  <= left_nx;
    end
  end
endmodule

// File: rtl/bus_wait_ctl.sv
module bus_wait_ctl
  import bwc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] wait_code,
  input  logic       wide_sel,
  input  logic       rdy_req,
  input  logic       int_acc,
  input  logic       ardy,
  input  logic       srdy,
  output logic       ph_t1,
  output logic       ph_t2,
  output logic       ph_t3,
  output logic       ph_tw,
  output logic       cyc_done
);
  phase_e            phase;
  logic              accept;
  logic              samp_pt;
  logic              ardy_sync;
  logic              rdy_eff;
  logic              need_lat;
  logic [WAIT_W-1:0] n_lat;
  logic [WAIT_W-1:0] left;

  bwc_rdy_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ardy),
    .dout  (ardy_sync)
  );

  assign rdy_eff = ardy_sync | srdy;

  bwc_cfg i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .code     (wait_code),
    .wide     (wide_sel),
    .req      (rdy_req),
    .intr     (int_acc),
    .n_lat    (n_lat),
    .need_lat (need_lat)
  );

  bwc_seq i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .n_waits (n_lat),
    .need    (need_lat),
    .rdy_eff (rdy_eff),
    .phase   (phase),
    .accept  (accept),
    .samp_pt (samp_pt),
    .left    (left)
  );

  assign ph_t1    = (phase == PH_T1);
  assign ph_t2    = (phase == PH_T2);
  assign ph_t3    = (phase == PH_T3);
  assign ph_tw    = (phase == PH_TW);
  assign cyc_done = (phase == PH_T4);
endmodule

// File: rtl/bwc_chk.sv
module bwc_chk
  import bwc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ardy,
  input logic              ardy_sync,
  input logic              rdy_eff,
  input logic              samp_pt,
  input logic              need_lat,
  input logic [WAIT_W-1:0] n_lat,
  input logic              ph_t1,
  input logic              ph_t2,
  input logic              ph_t3,
  input logic              ph_tw,
  input logic              cyc_done
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  ph_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_t1, ph_t2, ph_t3, ph_tw, cyc_done}));

  // R1
  t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_t1 |=> ph_t2);

  // R1
  t2_to_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_t2 |=> ph_t3);

  // R5
  miss_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_pt && !rdy_eff |=> ph_tw && samp_pt);

  // R4
  hit_one_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_pt && rdy_eff && n_lat != '0 |=> ph_tw ##1 cyc_done);

  // R4
  hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_pt && rdy_eff && n_lat == '0 |=> cyc_done);

  // R7
  no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_t3 && n_lat == '0 && !need_lat |=> cyc_done);

  // R9
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done && start |=> ph_t1);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done || $past(start));

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 |-> ardy_sync == $past(ardy, 2));
endmodule

bind bus_wait_ctl bwc_chk i_bwc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ardy      (ardy),
  .ardy_sync (ardy_sync),
  .rdy_eff   (rdy_eff),
  .samp_pt   (samp_pt),
  .need_lat  (need_lat),
  .n_lat     (n_lat),
  .ph_t1     (ph_t1),
  .ph_t2     (ph_t2),
  .ph_t3     (ph_t3),
  .ph_tw     (ph_tw),
  .cyc_done  (cyc_done)
);

// File: tb/test_bus_wait_ctl.sv
module test_bus_wait_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] wait_code = 3'd0;
  logic       wide_sel = 1'b0;
  logic       rdy_req = 1'b0;
  logic       int_acc = 1'b0;
  logic       ardy = 1'b0;
  logic       srdy = 1'b0;
  logic       ph_t1, ph_t2, ph_t3, ph_tw, cyc_done;

  int n_run  = 0;
  int n_fail = 0;

  bus_wait_ctl i_bus_wait_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_code(wait_code),
    .wide_sel(wide_sel), .rdy_req(rdy_req), .int_acc(int_acc),
    .ardy(ardy), .srdy(srdy), .ph_t1(ph_t1), .ph_t2(ph_t2),
    .ph_t3(ph_t3), .ph_tw(ph_tw), .cyc_done(cyc_done)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // R2: table restated arithmetically
  function automatic int n_of(input int code, input bit wide);
    if (!wide || code < 4) return code % 4;
    if (code == 7) return 15;
    return 2 * code - 3;
  endfunction

  function automatic int len_of(input int code, input bit wide, input bit req,
                                input bit intr, input int rdy_from);
    int n, p, t;
    n = intr ? 0 : n_of(code, wide);
    if (intr || !req) return 4 + n;
    p = (n <= 1) ? 3 : 2 + n;
    t = (rdy_from > p) ? rdy_from : p;
    return 4 + n + (t - p);
  endfunction

  // One access; srdy high from clock k+1 on; ardy raised in clock ardy_at.
  task automatic run_cyc(input int code, input bit wide, input bit req,
                         input bit intr, input int k, input int ardy_at,
                         input int exp, input string tag);
    int  len;
    bit  seq_ok;
    @(negedge clk);
    start = 1'b1; wait_code = 3'(code); wide_sel = wide;
    rdy_req = req; int_acc = intr;
    len = -1; seq_ok = 1'b1;
    for (int idx = 1; idx < 80; idx++) begin
      @(negedge clk);
      if (idx == 1) begin
        start = 1'b0;
        wait_code = ~wait_code; wide_sel = ~wide_sel;   // R10 scramble
        rdy_req = ~rdy_req; int_acc = ~int_acc;
        if (!ph_t1) seq_ok = 1'b0;
      end
      if (idx == 2 && !ph_t2) seq_ok = 1'b0;
      if (idx == 3 && !ph_t3) seq_ok = 1'b0;
      if (idx > 3 && !(ph_tw ^ cyc_done)) seq_ok = 1'b0;
      if (idx == ardy_at) ardy = 1'b1;
      srdy = (idx > k);
      if (cyc_done) begin
        len = idx;
        break;
      end
    end
    srdy = 1'b0;
    check(seq_ok, "R1 R8 phase order", int'(seq_ok), 1);
    check(len == exp, tag, len, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ks [5] = '{0, 3, 5, 8, 20};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({ph_t1, ph_t2, ph_t3, ph_tw, cyc_done} == 5'b0, "R1 reset idle",
          int'({ph_t1, ph_t2, ph_t3, ph_tw, cyc_done}), 0);

    // Main sweep: R2 R3 R4 R5 R7 R10
    for (int intr = 0; intr < 2; intr++)
      for (int req = 0; req < 2; req++)
        for (int wide = 0; wide < 2; wide++)
          for (int code = 0; code < 8; code++)
            for (int ki = 0; ki < 5; ki++) begin
              string tag;
              if (intr != 0)      tag = "R7 R10 length";
              else if (req == 0)  tag = "R2 R3 R10 length";
              else                tag = "R2 R4 R5 R10 length";
              run_cyc(code, wide[0], req[0], intr[0], ks[ki], -1,
                      len_of(code, wide[0], req[0], intr[0], ks[ki] + 1), tag);
            end

    // R6: asynchronous ready already high before the access
    ardy = 1'b1;
    repeat (3) @(negedge clk);
    run_cyc(2, 1'b0, 1'b1, 1'b0, 1000, -1, 6, "R6 ardy held");
    ardy = 1'b0;
    repeat (3) @(negedge clk);

    // R6: ardy raised in clock 5, usable at the sample in clock 7
    run_cyc(2, 1'b0, 1'b1, 1'b0, 1000, 5, 9, "R6 ardy mid-access");
    ardy = 1'b0;
    repeat (3) @(negedge clk);

    // R6: ardy raised in clock 1 for N=0, seen from clock 3 (T3)
    run_cyc(0, 1'b0, 1'b1, 1'b0, 1000, 1, 4, "R6 ardy early");
    ardy = 1'b0;
    repeat (3) @(negedge clk);

    // R3: ready ignored when not required, ardy high too
    ardy = 1'b1;
    run_cyc(5, 1'b1, 1'b0, 1'b0, 0, -1, 11, "R3 ready ignored");
    ardy = 1'b0;
    repeat (3) @(negedge clk);

    // R9: start held high across an access
    @(negedge clk);
    start = 1'b1; wait_code = 3'd0; wide_sel = 1'b0; rdy_req = 1'b0; int_acc = 1'b0;
    @(negedge clk);
    check(ph_t1 == 1'b1, "R9 first T1", int'(ph_t1), 1);
    @(negedge clk);
    check(ph_t2 == 1'b1, "R9 start ignored in T2", int'(ph_t2), 1);
    @(negedge clk);
    check(ph_t3 == 1'b1, "R9 start ignored in T3", int'(ph_t3), 1);
    @(negedge clk);
    check(cyc_done == 1'b1, "R8 R9 done", int'(cyc_done), 1);
    @(negedge clk);
    check(ph_t1 == 1'b1, "R9 back-to-back T1", int'(ph_t1), 1);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(cyc_done == 1'b1, "R8 second done", int'(cyc_done), 1);
    @(negedge clk);
    check({ph_t1, ph_t2, ph_t3, ph_tw, cyc_done} == 5'b0, "R8 R9 idle after",
          int'({ph_t1, ph_t2, ph_t3, ph_tw, cyc_done}), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule